// File: doc/BRIEF.md
# Card Slot Power Sequencing Controller

This block is the digital control core of a hot-plug card slot power switch. It reads the slot's logic-level status lines (an enable, the host's active-or-standby status, two active-low card detects for a PCIe-type and a USB-type card, and a host request to release the card from reset). It also reads per-rail power-good, input undervoltage and thermal fault flags that an analog front end provides. From these it drives the switch enables for three rails: auxiliary 3.3 V, primary 3.3 V and primary 1.5 V. It also drives a discharge enable for each rail, an active-low card reset, and the pull-down control of an open-drain reference-clock enable.

The enable, the card detects and the system status pick one of four modes. In shutdown nothing is powered and every output is discharged. With an empty slot nothing is powered. In standby only auxiliary power is on. In active mode all three rails are on. The reference clock is released only for a PCIe-type card whose rails are all good. The card reset is released only after a further timed delay, and only while the host requests it. A USB-only card gets power but no clock and no reset release. When the card is pulled, the enable drops or the host withdraws its request, reset is asserted within a few clock cycles. This happens no later than the cycle in which the switches open.

Top module: `slot_power_seq`

## Requirements
- R1: With the enable low or the thermal flag high, all three switch enables are 0, all three discharge enables are 1, card reset is 0 and the clock pull-down is 1.
- R2: With both card detects high (empty slot), all switch enables are 0, whatever the system status.
- R3: With a card detected and system status low, only the auxiliary rail is on: switch enable vector = 3'b001 (bit 0 auxiliary 3.3 V, bit 1 primary 3.3 V, bit 2 primary 1.5 V).
- R4: With a card detected and system status high, the switch enable vector is 3'b111.
- R5: Each rail's discharge enable is the complement of its switch enable; the two are never both 1.
- R6: An undervoltage flag on input rail i forces switch enable bit i to 0 (same bit order as R3) and leaves the other rails as the mode sets them.
- R7: The clock pull-down (1 = pin pulled low, 0 = pin released) is 0 only while all three rails are switched on, all three power-good flags are 1 and the PCIe-type detect is low. A USB-only card keeps it at 1.
- R8: Card reset goes to 1 only when the R7 release condition holds, the host request is 1 and that condition has held for DELAY cycles (CLK_HZ/1000*DELAY_US/1000). Reset rises exactly DELAY cycles after the clock pull-down falls, and the delay restarts whenever the condition is lost.
- R9: Removing the card, dropping the enable or dropping the host request brings card reset to 0 within 3 clock edges, and never later than the edge at which the switches open.
- R10: Every input passes through a two-flop synchroniser; outputs change at the third rising edge after an input change and not before.
- R11: When the host request returns high after the delay has already elapsed, card reset rises again within 3 edges, without a new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enableIn | input | 1 | Block enable, asynchronous |
| sysActiveIn | input | 1 | Host status: 1 active, 0 standby |
| pcieDetInN | input | 1 | PCIe-type card present, active low |
| usbDetInN | input | 1 | USB-type card present, active low |
| hostRstReqInN | input | 1 | Host request: 1 lets the card leave reset |
| pgoodIn | input | 3 | Per-rail output power-good flags |
| uvloIn | input | 3 | Per-rail input undervoltage flags |
| thermalIn | input | 1 | Thermal shutdown flag |
| swEn | output | 3 | Switch enables: bit 0 aux 3.3 V, bit 1 primary 3.3 V, bit 2 primary 1.5 V |
| dischEn | output | 3 | Output discharge enables, same bit order |
| cardRstN | output | 1 | Active-low card reset |
| clkPullDown | output | 1 | Open-drain clock enable: 1 pulls the pin low, 0 releases it |

## Verification
The hardest situation to reach from the ports is reset release after a host request falls and rises again once the delay has already run out. To get there, the stimulus first brings a PCIe-type card fully up and measures the exact cycle count from clock release to reset release. Then, with the rails held on, it toggles only the host request. A second hard case is delay restart after a single rail browns out. One undervoltage flag is raised and then cleared while power-good stays high, and the reset must stay low for a full new delay. The USB-only card is driven with all rails good for well beyond the delay, to show that neither clock nor reset is ever released.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

  localparam int RAILS = 3;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_EMPTY   = 2'd1,
    MODE_STANDBY = 2'd2,
    MODE_ACTIVE  = 2'd3
  } slot_mode_t;

  // Synchronised view of the slot inputs
  typedef struct packed {
    logic             enable;
    logic             sysActive;
    logic             pcieDetN;
    logic             usbDetN;
    logic             hostReqN;
    logic             thermal;
    logic [RAILS-1:0] pgood;
    logic [RAILS-1:0] uvlo;
  } slot_in_t;

  localparam int IN_W = $bits(slot_in_t);

  // Strobes from control to the output datapath
  typedef struct packed {
    logic [RAILS-1:0] railOn;
    logic             clkRelease;
    logic             rstRelease;
  } ctrl_strobe_t;

endpackage

// File: rtl/slot_in_sync.sv
module slot_in_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= RST_VAL;
          else       stage[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= RST_VAL;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned DELAY_US = 10_000
) (
  input  logic         clk,
  input  logic         rstN,
  input  slot_in_t     syn,
  output ctrl_strobe_t strobe
);

  localparam int unsigned CLK_KHZ   = CLK_HZ / 1000;
  localparam int unsigned DELAY_CYC = CLK_KHZ * DELAY_US / 1000;
  localparam int          CNT_W     = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DELAY_CYC);

  slot_mode_t       mode;
  logic [RAILS-1:0] railOn;
  logic             railsGood;
  logic [CNT_W-1:0] delayCnt;
  logic             delayDone;

  always_comb begin
    if (!syn.enable || syn.thermal)       mode = MODE_OFF;
    else if (syn.pcieDetN && syn.usbDetN) mode = MODE_EMPTY;
    else if (!syn.sysActive)              mode = MODE_STANDBY;
    else                                  mode = MODE_ACTIVE;
  end

  always_comb begin
    unique case (mode)
      MODE_ACTIVE:  railOn = {RAILS{1'b1}};
      MODE_STANDBY: railOn = RAILS'(1);
      default:      railOn = '0;
    endcase
    railOn = railOn & ~syn.uvlo;
  end

  assign railsGood = (&railOn) && (&syn.pgood) && !syn.pcieDetN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                delayCnt <= '0;
    else if (!railsGood)      delayCnt <= '0;
    else if (!delayDone)      delayCnt <= delayCnt + 1'b1;
  end

  assign delayDone = (delayCnt == CNT_LIM);

  assign strobe.railOn     = railOn;
  assign strobe.clkRelease = railsGood;
  assign strobe.rstRelease = railsGood && delayDone && syn.hostReqN;

  // R8
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    delayCnt <= CNT_LIM);

  // R8
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !railsGood |=> delayCnt == '0);

  // R1
  off_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!syn.enable || syn.thermal) |-> strobe.railOn == '0 && !strobe.rstRelease);

endmodule

// File: rtl/slot_out_path.sv
module slot_out_path
  import slot_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  output logic [RAILS-1:0] swEn,
  output logic [RAILS-1:0] dischEn,
  output logic             cardRstN,
  output logic             clkPullDown
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEn        <= '0;
      dischEn     <= {RAILS{1'b1}};
      cardRstN    <= 1'b0;
      clkPullDown <= 1'b1;
    end else begin
      swEn        <= strobe.railOn;
      dischEn     <= ~strobe.railOn;
      cardRstN    <= strobe.rstRelease;
      clkPullDown <= ~strobe.clkRelease;
    end
  end

  genvar r;
  generate
    for (r = 0; r < RAILS; r++) begin : g_rail_chk
      // R5
      no_fight_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(swEn[r] && dischEn[r]) && (swEn[r] || dischEn[r]));
    end
  endgenerate

  // R7
  rst_needs_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardRstN |-> !clkPullDown && (&swEn));

  // R9
  rst_before_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swEn[1]) |-> !cardRstN);

endmodule

// File: rtl/slot_power_seq.sv
module slot_power_seq
  import slot_pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned DELAY_US = 10_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableIn,
  input  logic       sysActiveIn,
  input  logic       pcieDetInN,
  input  logic       usbDetInN,
  input  logic       hostRstReqInN,
  input  logic [2:0] pgoodIn,
  input  logic [2:0] uvloIn,
  input  logic       thermalIn,
  output logic [2:0] swEn,
  output logic [2:0] dischEn,
  output logic       cardRstN,
  output logic       clkPullDown
);

  localparam slot_in_t SYNC_RST = '{enable: 1'b0, sysActive: 1'b0,
                                    pcieDetN: 1'b1, usbDetN: 1'b1,
                                    hostReqN: 1'b0, thermal: 1'b0,
                                    pgood: '0, uvlo: '0};

  slot_in_t     rawIn;
  slot_in_t     synIn;
  ctrl_strobe_t strobe;

  assign rawIn = '{enable: enableIn, sysActive: sysActiveIn,
                   pcieDetN: pcieDetInN, usbDetN: usbDetInN,
                   hostReqN: hostRstReqInN, thermal: thermalIn,
                   pgood: pgoodIn, uvlo: uvloIn};

  slot_in_sync #(.WIDTH(IN_W), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(synIn)
  );

  slot_seq_ctrl #(.CLK_HZ(CLK_HZ), .DELAY_US(DELAY_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .syn(synIn), .strobe(strobe)
  );

  slot_out_path u_out (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .swEn(swEn), .dischEn(dischEn), .cardRstN(cardRstN),
    .clkPullDown(clkPullDown)
  );

endmodule

// File: tb/tb_slot_power_seq.sv
`timescale 1ns/1ps
module tb_slot_power_seq;

  localparam int DELAY = 125;  // 125 MHz, 1 us

  logic clk = 0;
  logic rstN = 0;
  logic enableIn = 0, sysActiveIn = 0, pcieDetInN = 1, usbDetInN = 1;
  logic hostRstReqInN = 0, thermalIn = 0;
  logic [2:0] pgoodIn = '0, uvloIn = '0;
  logic [2:0] swEn, dischEn;
  logic cardRstN, clkPullDown;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] sw;
    logic [2:0] di;
    logic       rst;
    logic       pd;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  always #4 clk = ~clk;

  slot_power_seq #(.CLK_HZ(125_000_000), .DELAY_US(1)) dut (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .sysActiveIn(sysActiveIn),
    .pcieDetInN(pcieDetInN), .usbDetInN(usbDetInN),
    .hostRstReqInN(hostRstReqInN), .pgoodIn(pgoodIn), .uvloIn(uvloIn),
    .thermalIn(thermalIn), .swEn(swEn), .dischEn(dischEn),
    .cardRstN(cardRstN), .clkPullDown(clkPullDown)
  );

  task automatic expect_after(input int edges, input logic [2:0] sw,
                              input logic rst, input logic pd, input string tag);
    exp_t e;
    repeat (edges) @(negedge clk);
    e.sw = sw; e.di = ~sw; e.rst = rst; e.pd = pd; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (swEn !== e.sw || dischEn !== e.di || cardRstN !== e.rst ||
            clkPullDown !== e.pd) begin
          failures++;
          $display("FAIL %s actual sw=%b di=%b rst=%b pd=%b expected sw=%b di=%b rst=%b pd=%b",
                   e.tag, swEn, dischEn, cardRstN, clkPullDown,
                   e.sw, e.di, e.rst, e.pd);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    expect_after(1, 3'b000, 1'b0, 1'b1, "R1 reset state");

    // R2: slot empty, system active
    enableIn = 1; sysActiveIn = 1;
    expect_after(4, 3'b000, 1'b0, 1'b1, "R2 empty slot active");

    // R3: card present, standby
    sysActiveIn = 0; pcieDetInN = 0; pgoodIn = 3'b001;
    expect_after(4, 3'b001, 1'b0, 1'b1, "R3 standby aux only");

    // R10 latency, R4 and R7
    sysActiveIn = 1; pgoodIn = 3'b111; hostRstReqInN = 1;
    expect_after(2, 3'b001, 1'b0, 1'b1, "R10 unchanged after two edges");
    expect_after(1, 3'b111, 1'b0, 1'b0, "R4 R7 rails on clock released");

    // R8 exact delay from clock release to reset release
    n = 0;
    while (!cardRstN && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check_int("R8 reset delay cycles", n, DELAY);
    expect_after(0, 3'b111, 1'b1, 1'b0, "R8 reset released");

    // R9 host request drop
    hostRstReqInN = 0;
    expect_after(3, 3'b111, 1'b0, 1'b0, "R9 host request fall");
    // R11 request returns after delay elapsed
    hostRstReqInN = 1;
    expect_after(3, 3'b111, 1'b1, 1'b0, "R11 release without new delay");

    // R6 undervoltage on the 1.5 V rail, then R8 restart
    uvloIn = 3'b100;
    expect_after(3, 3'b011, 1'b0, 1'b1, "R6 R5 uvlo bit2");
    uvloIn = 3'b000;
    expect_after(3, 3'b111, 1'b0, 1'b0, "R8 delay restarts");
    expect_after(DELAY - 5, 3'b111, 1'b0, 1'b0, "R8 still held before delay");
    expect_after(10, 3'b111, 1'b1, 1'b0, "R8 released after new delay");

    // R9 surprise removal, R2 independence of system status
    pcieDetInN = 1;
    expect_after(3, 3'b000, 1'b0, 1'b1, "R9 R2 card removal");
    sysActiveIn = 0;
    expect_after(3, 3'b000, 1'b0, 1'b1, "R2 empty slot standby");

    // R7 USB-only card
    sysActiveIn = 1; usbDetInN = 0;
    expect_after(3 * DELAY, 3'b111, 1'b0, 1'b1, "R7 usb-only no clock no reset");

    // R1 and R9 enable fall from fully released state
    usbDetInN = 1; pcieDetInN = 0;
    expect_after(DELAY + 10, 3'b111, 1'b1, 1'b0, "R4 pcie card up");
    enableIn = 0;
    expect_after(3, 3'b000, 1'b0, 1'b1, "R1 R9 enable fall");

    // R1 thermal flag
    enableIn = 1;
    expect_after(DELAY + 10, 3'b111, 1'b1, 1'b0, "R4 re-enabled");
    thermalIn = 1;
    expect_after(3, 3'b000, 1'b0, 1'b1, "R1 thermal shutdown");
    thermalIn = 0;
    expect_after(DELAY + 10, 3'b111, 1'b1, 1'b0, "R8 recovered after thermal");

    // R3 active to standby, R6 on aux rail
    sysActiveIn = 0;
    expect_after(3, 3'b001, 1'b0, 1'b1, "R3 active to standby");
    uvloIn = 3'b001;
    expect_after(3, 3'b000, 1'b0, 1'b1, "R6 uvlo aux rail");

    wait (sbq.size() == 0);
    @(negedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule